// File: doc/BRIEF.md
# Strobed Burst Transmitter with Pause

This block is the sending side of a parallel data-out burst. Words of `WORD_W` bits arrive on a valid/ready stream. Each word is placed on an output data bus, then latched at the receiver by one transition of a toggling strobe. The strobe idles high, so the first word is marked by a falling transition, the second by a rising one, and so on.

Every timing rule on the link is a parameter counted in clock cycles:
- the data setup before a strobe transition;
- the data hold after it;
- the minimum spacing between any two transitions;
- the minimum spacing between two transitions of the same polarity;
- how long the receiver's active-low ready must have been asserted before the first transition.

Within these limits, the block makes each transition at the first clock at which all of them are met.

A burst pauses whenever the strobe is simply not toggled. This happens when no word is waiting, or when the pause request input is high once the first word has gone out. A pause request raised before the first word has no effect. The burst resumes with the next transition. Termination, checksum exchange and pad timing sit outside this block.

Top module: `strobed_burst_tx`

## Requirements
- R1: While reset is held and right after it, `strobe` is 1, `bus_data` is all zeros and `in_ready` is 1.
- R2: A word is taken on a clock where `in_valid` and `in_ready` are both 1. `in_ready` is 0 while an accepted word waits for its transition. After a transition at clock n, `in_ready` stays 0 until a word can be taken at clock n+HOLD_CYC, and not before.
- R3: Every strobe transition marks exactly one accepted word, in order of acceptance. While that word waits, `bus_data` shows it unchanged.
- R4: The first transition after reset happens only once `dev_rdy_n` has been sampled 0 on LI_CYC consecutive clocks. With a word already waiting, it falls on the next clock after that.
- R5: No transition happens on a clock where `dev_rdy_n` is sampled 1. After the first word, a transition needs only `dev_rdy_n` sampled 0 on that clock.
- R6: A transition happens no fewer than SETUP_CYC clocks after `bus_data` last changed.
- R7: Consecutive transitions are no fewer than CYC_MIN clocks apart. Two transitions of the same polarity are no fewer than PAIR_MIN clocks apart.
- R8: A transition is made at the first clock at which all conditions in R3 to R7 and R10 hold.
- R9: When no word is waiting, `strobe` does not change. A word accepted at clock a into an idle, fully spaced link is marked at clock a+SETUP_CYC.
- R10: While `pause_req` is 1 after the first transition, `strobe` does not change and the waiting word stays on `bus_data`. The transition follows on the clock after `pause_req` is sampled 0.
- R11: `pause_req` has no effect before the first transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | WORD_W | Word offered on the input stream |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this clock |
| pause_req | input | 1 | Request to hold the burst after the first word |
| dev_rdy_n | input | 1 | Receiver ready, active low |
| bus_data | output | WORD_W | Data bus to the receiver |
| strobe | output | 1 | Toggling latch strobe, idles high |

## Verification
A word taken at a clock is on `bus_data` just after that clock. Its transition is due SETUP_CYC clocks later, or later still if spacing, ready or pause holds it back. After a transition, `in_ready` is due back HOLD_CYC-1 clocks later.

Other latencies the bench relies on:
- The first transition lands LI_CYC+1 clocks after the clock at which `dev_rdy_n` is driven low.
- Releasing `pause_req` or `dev_rdy_n` mid-burst yields the transition one clock later.
- Under a steady stream, the gap before each transition is max(SETUP_CYC+HOLD_CYC, CYC_MIN), stretched to PAIR_MIN minus the previous gap when needed.

The bench stamps every clock with a cycle number. It drives inputs and samples outputs on falling clock edges. It compares the recorded transition cycles against these figures, computed from the parameters.

// File: rtl/sbt_pkg.sv
// Shared constants for the strobed burst transmitter.
// Assumes: timer slots are indexed by the constants below.
package sbt_pkg;
    localparam int DEF_WORD_W = 16;
    localparam int TM_SETUP   = 0;
    localparam int TM_HOLD    = 1;
    localparam int TM_GAP     = 2;
    localparam int NUM_TIMERS = 3;
endpackage

// File: rtl/sbt_interval_timer.sv
// Saturating interval timer: counts clocks since its last restart.
// The count is 1 during the cycle after a restart and stops at all ones.
// Reset loads all ones, meaning "interval long expired".
module sbt_interval_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Restart to one, else climb until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= CNT_MAX;
        else if (restart)        count <= CNT_W'(1);
        else if (count != CNT_MAX) count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/sbt_ready_qualifier.sv
// Counts consecutive clocks with the receiver's active-low ready sampled low.
// Flags when the count reaches the limit needed before the first strobe edge.
// Assumes: dev_rdy_n is synchronous to clk.
module sbt_ready_qualifier #(
    parameter int CNT_W  = 6,
    parameter int LI_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_rdy_n,
    output logic [CNT_W-1:0] rdy_cnt,
    output logic             rdy_settled
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Track the run length of asserted ready.
    always_ff @(posedge clk) begin
        if (!rst_n)              rdy_cnt <= '0;
        else if (dev_rdy_n)      rdy_cnt <= '0;
        else if (rdy_cnt != CNT_MAX) rdy_cnt <= rdy_cnt + CNT_W'(1);
    end

    // Limit reached.
    always_comb rdy_settled = (rdy_cnt >= CNT_W'(LI_CYC));

    // A negated ready clears the run.
    p_rdy_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dev_rdy_n) |-> rdy_cnt == '0);
endmodule

// File: rtl/sbt_word_holder.sv
// Holds one word on the data bus from acceptance until its strobe edge.
// Assumes: fire is only raised while loaded is set.
module sbt_word_holder #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              hold_done,
    input  logic              fire,
    output logic              in_ready,
    output logic              accept,
    output logic              loaded,
    output logic [WORD_W-1:0] bus_data
);
    // Take a word only when empty and the hold interval is over.
    always_comb begin
        in_ready = !loaded && hold_done;
        accept   = in_valid && in_ready;
    end

    // Occupancy flag: set on accept, cleared by the latching edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      loaded <= 1'b0;
        else if (accept) loaded <= 1'b1;
        else if (fire)   loaded <= 1'b0;
    end

    // Bus register: changes only when a new word is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_data <= '0;
        else if (accept) bus_data <= in_data;
    end

    p_accept_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid && in_ready) |-> loaded && bus_data == $past(in_data));
    p_bus_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(loaded) && loaded |-> $stable(bus_data));
endmodule

// File: rtl/sbt_strobe_pacer.sv
// Decides when to toggle the strobe and keeps the edge-spacing history.
// An edge needs:
//   - a loaded word with setup met;
//   - single and same-polarity spacing met;
//   - ready asserted;
//   - the first-edge ready run satisfied, or no pause request afterwards.
// Assumes: timer counts saturate rather than wrap.
module sbt_strobe_pacer #(
    parameter int CNT_W     = 6,
    parameter int SETUP_CYC = 2,
    parameter int CYC_MIN   = 3,
    parameter int PAIR_MIN  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loaded,
    input  logic [CNT_W-1:0] setup_cnt,
    input  logic [CNT_W-1:0] gap_cnt,
    input  logic             dev_rdy_n,
    input  logic             rdy_settled,
    input  logic             pause_req,
    output logic             fire,
    output logic             strobe,
    output logic             started
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] prev_gap;
    logic             setup_ok, gap_ok, pair_ok, gate_ok;

    // Edge permission from all timing and flow conditions.
    always_comb begin
        setup_ok = setup_cnt >= CNT_W'(SETUP_CYC);
        gap_ok   = gap_cnt >= CNT_W'(CYC_MIN);
        pair_ok  = ({1'b0, prev_gap} + {1'b0, gap_cnt}) >= SUM_W'(PAIR_MIN);
        gate_ok  = started ? !pause_req : rdy_settled;
        fire     = loaded && setup_ok && gap_ok && pair_ok && !dev_rdy_n && gate_ok;
    end

    // Strobe toggles once per latched word, idling high.
    always_ff @(posedge clk) begin
        if (!rst_n)    strobe <= 1'b1;
        else if (fire) strobe <= ~strobe;
    end

    // Remember the previous gap for the same-polarity rule.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_gap <= '1;
        else if (fire) prev_gap <= gap_cnt;
    end

    // Marks that the first word of the burst has gone out.
    always_ff @(posedge clk) begin
        if (!rst_n)    started <= 1'b0;
        else if (fire) started <= 1'b1;
    end

    p_edge_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(strobe) |-> $past(!dev_rdy_n));
    p_edge_needs_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(strobe) |-> $past(loaded));
    p_gap_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(strobe) |-> $past(gap_cnt) >= CNT_W'(CYC_MIN));
    p_pause_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(pause_req && started) |-> $stable(strobe));
endmodule

// File: rtl/strobed_burst_tx.sv
// Host-side strobed burst transmitter with pause.
// Accepts words from a valid/ready stream, places each on the data bus and
// marks it with one strobe transition. Setup, hold, spacing and first-edge
// ready timing are enforced as clock counts.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module strobed_burst_tx
    import sbt_pkg::*;
#(
    parameter int WORD_W    = DEF_WORD_W,
    parameter int CNT_W     = 6,
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 2,
    parameter int CYC_MIN   = 3,
    parameter int PAIR_MIN  = 9,
    parameter int LI_CYC    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              pause_req,
    input  logic              dev_rdy_n,
    output logic [WORD_W-1:0] bus_data,
    output logic              strobe
);
    logic [NUM_TIMERS-1:0] restart;
    logic [CNT_W-1:0]      tcount [NUM_TIMERS];
    logic [CNT_W-1:0]      rdy_cnt;
    logic                  rdy_settled, accept, loaded, fire, started, hold_done;

    // Timer restart sources: setup from a load, hold and gap from an edge.
    always_comb begin
        restart[TM_SETUP] = accept;
        restart[TM_HOLD]  = fire;
        restart[TM_GAP]   = fire;
        hold_done         = tcount[TM_HOLD] >= CNT_W'(HOLD_CYC);
    end

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_timer
        sbt_interval_timer #(.CNT_W(CNT_W)) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart[i]),
            .count   (tcount[i])
        );
    end

    sbt_ready_qualifier #(.CNT_W(CNT_W), .LI_CYC(LI_CYC)) u_rdy (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_rdy_n   (dev_rdy_n),
        .rdy_cnt     (rdy_cnt),
        .rdy_settled (rdy_settled)
    );

    sbt_word_holder #(.WORD_W(WORD_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .hold_done (hold_done),
        .fire      (fire),
        .in_ready  (in_ready),
        .accept    (accept),
        .loaded    (loaded),
        .bus_data  (bus_data)
    );

    sbt_strobe_pacer #(
        .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .CYC_MIN(CYC_MIN), .PAIR_MIN(PAIR_MIN)
    ) u_pace (
        .clk         (clk),
        .rst_n       (rst_n),
        .loaded      (loaded),
        .setup_cnt   (tcount[TM_SETUP]),
        .gap_cnt     (tcount[TM_GAP]),
        .dev_rdy_n   (dev_rdy_n),
        .rdy_settled (rdy_settled),
        .pause_req   (pause_req),
        .fire        (fire),
        .strobe      (strobe),
        .started     (started)
    );

    p_first_edge_li_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(strobe) && !$past(started) |-> $past(rdy_cnt) >= CNT_W'(LI_CYC));
    p_setup_met_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(strobe) |-> $past(tcount[TM_SETUP]) >= CNT_W'(SETUP_CYC));
    p_hold_before_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(bus_data) |-> $past(tcount[TM_HOLD]) >= CNT_W'(HOLD_CYC));
endmodule

// File: tb/strobed_burst_tx_test.sv
`timescale 1ns/1ps
module strobed_burst_tx_test;
    localparam int WORD_W = 16, SETUP = 2, HOLD = 2, CYCM = 3, PAIR = 9, LI = 4;
    localparam int NSTREAM = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [WORD_W-1:0] in_data = '0;
    logic in_valid = 1'b0, pause_req = 1'b0, dev_rdy_n = 1'b1;
    logic in_ready, strobe;
    logic [WORD_W-1:0] bus_data;

    strobed_burst_tx #(.WORD_W(WORD_W), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD),
        .CYC_MIN(CYCM), .PAIR_MIN(PAIR), .LI_CYC(LI)) uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .pause_req(pause_req), .dev_rdy_n(dev_rdy_n),
        .bus_data(bus_data), .strobe(strobe));

    always #2 clk = ~clk;   // 250 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;
    logic [WORD_W-1:0] sb[$];   // scoreboard of accepted words
    int edge_q[$];              // cycles of strobe transitions
    int accept_cyc = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Driver: offers a word, waits for acceptance, records it as expected.
    task automatic send(input logic [WORD_W-1:0] w);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        accept_cyc = cyc;
        sb.push_back(w);
        in_valid = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        for (int t = 0; t < 300 && edge_q.size() < n; t++) tick();
    endtask

    function automatic int last_edge();
        return (edge_q.size() == 0) ? -1 : edge_q[edge_q.size()-1];
    endfunction

    // Monitor: compares each marked word and checks spacing, setup and hold.
    logic last_strobe = 1'b1;
    logic [WORD_W-1:0] last_bus = '0;
    int last_bus_cyc = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (strobe !== last_strobe) begin
                if (sb.size() == 0) chk(1'b0, "R3 edge without word", 0, 1);
                else begin
                    logic [WORD_W-1:0] e;
                    e = sb.pop_front();
                    chk(bus_data === e, "R3 marked word", int'(bus_data), int'(e));
                end
                chk(cyc - last_bus_cyc >= SETUP, "R6 setup", cyc - last_bus_cyc, SETUP);
                if (edge_q.size() >= 1)
                    chk(cyc - edge_q[edge_q.size()-1] >= CYCM, "R7 gap",
                        cyc - edge_q[edge_q.size()-1], CYCM);
                if (edge_q.size() >= 2)
                    chk(cyc - edge_q[edge_q.size()-2] >= PAIR, "R7 pair",
                        cyc - edge_q[edge_q.size()-2], PAIR);
                edge_q.push_back(cyc);
                last_strobe = strobe;
            end
            if (bus_data !== last_bus) begin
                if (edge_q.size() > 0)
                    chk(cyc - last_edge() >= HOLD, "R2 hold", cyc - last_edge(), HOLD);
                last_bus = bus_data;
                last_bus_cyc = cyc;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int c, n, p, prev, g;
        repeat (3) tick();
        // R1: reset values
        chk(strobe === 1'b1, "R1 strobe", int'(strobe), 1);
        chk(bus_data === '0, "R1 bus", int'(bus_data), 0);
        chk(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);
        rst_n = 1'b1;
        tick();
        chk(strobe === 1'b1 && in_ready === 1'b1, "R1 after release", int'(strobe), 1);

        // R11 with R5: pause raised early, receiver not ready; stream starts
        pause_req = 1'b1;
        fork
            begin
                for (int i = 0; i < NSTREAM; i++) send(WORD_W'(16'hA100 + i * 16'h0111));
            end
        join_none
        repeat (10) tick();
        chk(edge_q.size() == 0, "R5 no edge while not ready", edge_q.size(), 0);
        chk(in_ready === 1'b0, "R2 busy while word waits", int'(in_ready), 0);

        // R4: first edge LI+1 clocks after ready is driven low, pause ignored (R11)
        c = cyc;
        dev_rdy_n = 1'b0;
        wait_edges(1);
        chk(last_edge() == c + LI + 1, "R4 first edge timing / R11", last_edge(), c + LI + 1);
        pause_req = 1'b0;

        // R8: steady-stream gaps follow the spacing recurrence
        wait_edges(NSTREAM);
        chk(edge_q.size() == NSTREAM, "R8 stream edges", edge_q.size(), NSTREAM);
        prev = 1000;
        for (int k = 1; k < NSTREAM && k < edge_q.size(); k++) begin
            g = (SETUP + HOLD > CYCM) ? SETUP + HOLD : CYCM;
            if (prev + g < PAIR) g = PAIR - prev;
            chk(edge_q[k] - edge_q[k-1] == g, "R8 gap", edge_q[k] - edge_q[k-1], g);
            prev = g;
        end

        // R9: dry input holds strobe; a new word resumes after setup
        n = edge_q.size();
        repeat (12) tick();
        chk(edge_q.size() == n, "R9 no edge when dry", edge_q.size(), n);
        send(16'h5A5A);
        wait_edges(n + 1);
        chk(last_edge() == accept_cyc + SETUP, "R9 resume timing", last_edge(), accept_cyc + SETUP);

        // R10: pause mid-burst holds strobe and bus, releases one clock later
        tick();
        pause_req = 1'b1;
        send(16'hC3C3);
        n = edge_q.size();
        repeat (10) tick();
        chk(edge_q.size() == n, "R10 paused no edge", edge_q.size(), n);
        chk(bus_data === 16'hC3C3, "R10 bus held", int'(bus_data), 'hC3C3);
        chk(in_ready === 1'b0, "R2 busy while paused", int'(in_ready), 0);
        p = cyc;
        pause_req = 1'b0;
        tick();
        chk(last_edge() == p + 1, "R10 resume timing", last_edge(), p + 1);
        chk(in_ready === 1'b0, "R2 hold blocks load", int'(in_ready), 0);
        tick();
        chk(in_ready === 1'b1, "R2 ready after hold", int'(in_ready), 1);

        // R5: receiver not ready mid-burst; later edges need only current ready
        dev_rdy_n = 1'b1;
        send(16'h0F0F);
        n = edge_q.size();
        repeat (10) tick();
        chk(edge_q.size() == n, "R5 no edge mid-burst", edge_q.size(), n);
        p = cyc;
        dev_rdy_n = 1'b0;
        wait_edges(n + 1);
        chk(last_edge() == p + 1, "R5 resume timing", last_edge(), p + 1);

        repeat (4) tick();
        chk(sb.size() == 0, "R3 all words marked", sb.size(), 0);
        finish_run();
    end
endmodule